// File: doc/BRIEF.md
# Interrupt Controller with Vector Register

This block collects a parameterised number of interrupt inputs (1 to 32) and drives a single interrupt request line towards a processor. Each input is fixed at elaboration time as either edge-sensitive or level-sensitive by a bit mask parameter. A captured input sets a bit in a status register. The status is qualified by a per-input enable register, and the result is the pending set. The request line is raised only when software has opened a two-bit master gate.

Software works through a 32-bit register port made of a write strobe, a read strobe and a three-bit word index. The index is the byte offset divided by four. Software acknowledges captured inputs by writing a mask of ones. It can change enables one at a time through separate set and clear aliases, so there is no read-modify-write race. It reads a vector register to get the number of the lowest active input directly. The port has no back-pressure. Every access completes in the cycle it is strobed, and read data is combinational from the current register state.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read zero, `irq_out` is low, and the vector register (word 6) reads 0xFFFFFFFF.
- R2: A level-sensitive input (mask bit clear) sets its status bit (word 0) on every clock edge at which it is high, so the bit returns right after an acknowledge while the source is still high.
- R3: An edge-sensitive input (mask bit set) sets its status bit only on a clock edge where it is high and was low at the previous edge; once acknowledged, an input held high leaves the bit clear.
- R4: Writing a mask to word 3 clears the status bits at the positions of its ones; if an input capture hits the same bit in the same cycle, the capture wins.
- R5: Writing word 2 replaces the whole enable register with the low N_IRQ bits of the data; writing 0 disables every input.
- R6: Writing a mask to word 4 sets those enable bits, and writing a mask to word 5 clears them; all other enable bits keep their values.
- R7: Reading word 1 returns the status bits ANDed with the enable bits.
- R8: Reading word 6 returns the index of the lowest-numbered pending input, or 0xFFFFFFFF when no input is pending.
- R9: Word 7 holds two master bits (bit 0 master, bit 1 hardware gate); `irq_out` is high exactly when both are 1 and at least one input is pending.
- R10: Words 3, 4 and 5 read zero; `rdata` is zero whenever `rd_en` is low; writes to word 0 have no effect; bits at and above N_IRQ read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Interrupt source lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The capture path is tested with a level source held across an acknowledge and with an edge source held across an acknowledge. Only the edge source stays cleared, and this separates the two sensitivities. The enable path is tested with whole-register writes, set-only and clear-only masks, and an enable subset smaller than the captured set. Any difference between pending and status, or between the vector and the lowest pending input, shows up on reads. The master gate is tested through all four two-bit combinations while an input is pending, so an output that ignores either bit is detected.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DATA_W);

  // word index = byte offset / 4; software depends on this order
  typedef enum logic [2:0] {
    REG_STS = 3'd0,
    REG_PND = 3'd1,
    REG_ENA = 3'd2,
    REG_ACK = 3'd3,
    REG_SET = 3'd4,
    REG_CLR = 3'd5,
    REG_VEC = 3'd6,
    REG_MST = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int          N_IRQ     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] ack,
  output logic [N_IRQ-1:0] sts
);
  logic [N_IRQ-1:0] hit;

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_src
    if (EDGE_MASK[gi]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[gi];
      end
      assign hit[gi] = irq_in[gi] & ~prev_q;
    end else begin : g_level
      assign hit[gi] = irq_in[gi];
    end
  end

  // a fresh capture beats an acknowledge of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~ack) | hit;
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import intc_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [N_IRQ-1:0] wmask,
  input  logic [1:0]       mst_in,
  output logic [N_IRQ-1:0] ena,
  output logic [1:0]       mst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena <= '0;
      mst <= 2'b00;
    end else if (wr_en) begin
      case (sel)
        REG_ENA: ena <= wmask;
        REG_SET: ena <= ena | wmask;
        REG_CLR: ena <= ena & ~wmask;
        REG_MST: mst <= mst_in;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest
  import intc_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import intc_pkg::*;
#(
  parameter int          N_IRQ     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);
  reg_sel_e         sel;
  logic [N_IRQ-1:0] wmask;
  logic [N_IRQ-1:0] ack_vec;
  logic [N_IRQ-1:0] sts_q;
  logic [N_IRQ-1:0] ena_q;
  logic [N_IRQ-1:0] pend;
  logic [1:0]       mst_q;
  logic             any_pend;
  logic [IDX_W-1:0] low_idx;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(addr);
  assign wmask        = wdata[N_IRQ-1:0];
  assign ack_vec      = (wr_en && sel == REG_ACK) ? wmask : '0;
  assign unused_wdata = ^wdata;

  irq_capture #(.N_IRQ(N_IRQ), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack_vec), .sts(sts_q)
  );

  irq_mask_regs #(.N_IRQ(N_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wmask(wmask),
    .mst_in(wdata[1:0]), .ena(ena_q), .mst(mst_q)
  );

  assign pend = sts_q & ena_q;

  irq_lowest #(.N_IRQ(N_IRQ)) u_low (
    .req(pend), .hit(any_pend), .idx(low_idx)
  );

  assign irq_out = (mst_q == 2'b11) && any_pend;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        REG_STS: rdata[N_IRQ-1:0] = sts_q;
        REG_PND: rdata[N_IRQ-1:0] = pend;
        REG_ENA: rdata[N_IRQ-1:0] = ena_q;
        REG_VEC: rdata = any_pend ? DATA_W'(low_idx) : '1;
        REG_MST: rdata[1:0] = mst_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int          N_IRQ     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IRQ-1:0] irq_in,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             irq_out,
  input logic [N_IRQ-1:0] sts,
  input logic [N_IRQ-1:0] ena
);
  logic [N_IRQ-1:0] pend_c;
  logic [N_IRQ-1:0] pend_sh;
  assign pend_c  = sts & ena;
  assign pend_sh = pend_c >> rdata[4:0];

  for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_bit
    if (EDGE_MASK[gi]) begin : g_edge
      // R3: acknowledge of a held edge source stays cleared
      p_edge_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd3 && wdata[gi] && irq_in[gi] && $past(irq_in[gi]) && $past(rst_n))
        |=> !sts[gi]);
    end else begin : g_level
      // R2: a high level source is always captured
      p_level_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[gi] |=> sts[gi]);
    end
  end

  p_set_ena_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> ena == ($past(ena) | $past(wdata[N_IRQ-1:0])));

  p_clr_ena_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> ena == ($past(ena) & ~$past(wdata[N_IRQ-1:0])));

  p_vec_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd6 && rdata != 32'hFFFF_FFFF) |-> (rdata < N_IRQ) && pend_sh[0]);

  p_wo_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 3'd3 || addr == 3'd4 || addr == 3'd5)) |-> rdata == 32'd0);

  p_gate_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7 && rdata[1:0] != 2'b11) |-> !irq_out);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_IRQ(N_IRQ), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
  .sts(sts_q), .ena(ena_q)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 8;
  localparam logic [31:0] EMASK      = 32'h0000_00F0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit m_sts[N];
  bit m_ena[N];
  bit m_prev[N];
  int m_mst;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl #(.N_IRQ(N), .EDGE_MASK(EMASK)) i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] exp_read(input logic re, input int a);
    logic [31:0] v = 0;
    if (!re) return 0;
    case (a)
      0: for (int i = 0; i < N; i++) v[i] = m_sts[i];
      1: for (int i = 0; i < N; i++) v[i] = m_sts[i] && m_ena[i];
      2: for (int i = 0; i < N; i++) v[i] = m_ena[i];
      6: begin
        v = 32'hFFFF_FFFF;
        for (int i = 0; i < N; i++)
          if (m_sts[i] && m_ena[i] && v == 32'hFFFF_FFFF) v = i;
      end
      7: v = m_mst;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic logic exp_irq();
    int n = 0;
    for (int i = 0; i < N; i++) if (m_sts[i] && m_ena[i]) n++;
    return (m_mst == 3) && (n > 0);
  endfunction

  task automatic step(input logic [N-1:0] in, input logic we, input logic re,
                      input int a, input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        ei;
    irq_in = in; wr_en = we; rd_en = re; addr = a[2:0]; wdata = d;
    #1;
    er = exp_read(re, a);
    ei = exp_irq();
    checks++;
    if (rdata !== er) begin
      errors++;
      $display("FAIL %s rdata word %0d: actual %h expected %h", tag, a, rdata, er);
    end
    checks++;
    if (irq_out !== ei) begin
      errors++;
      $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, ei);
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      bit cap = EMASK[i] ? (in[i] && !m_prev[i]) : in[i];
      bit clr = we && a == 3 && d[i];
      if (cap) m_sts[i] = 1;
      else if (clr) m_sts[i] = 0;
      m_prev[i] = in[i];
    end
    if (we) begin
      for (int i = 0; i < N; i++) begin
        if (a == 2) m_ena[i] = d[i];
        if (a == 4 && d[i]) m_ena[i] = 1;
        if (a == 5 && d[i]) m_ena[i] = 0;
      end
      if (a == 7) m_mst = d[1:0];
    end
    @(negedge clk);
  endtask

  initial begin
    m_mst = 0;
    for (int i = 0; i < N; i++) begin m_sts[i] = 0; m_ena[i] = 0; m_prev[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(8'h00, 0, 1, 0, 0, "R1");
    step(8'h00, 0, 1, 2, 0, "R1");
    step(8'h00, 0, 1, 7, 0, "R1");
    step(8'h00, 0, 1, 6, 0, "R1");
    // open everything
    step(8'h00, 1, 0, 2, 32'hFF, "R5");
    step(8'h00, 1, 0, 7, 32'h3, "R9");
    // R2 level source held across acknowledge
    for (int k = 0; k < 3; k++) step(8'h02, 0, 1, 0, 0, "R2");
    step(8'h02, 1, 1, 0, 32'h02, "R4");
    step(8'h02, 1, 0, 3, 32'h02, "R4");
    step(8'h02, 0, 1, 0, 0, "R2");
    step(8'h00, 1, 0, 3, 32'h02, "R4");
    step(8'h00, 0, 1, 0, 0, "R4");
    // R3 edge source held across acknowledge, then a new rise
    step(8'h20, 0, 1, 0, 0, "R3");
    step(8'h20, 0, 1, 0, 0, "R3");
    step(8'h20, 1, 0, 3, 32'h20, "R3");
    step(8'h20, 0, 1, 0, 0, "R3");
    step(8'h20, 0, 1, 6, 0, "R3");
    step(8'h00, 0, 1, 0, 0, "R3");
    step(8'h20, 0, 1, 0, 0, "R3");
    step(8'h00, 1, 0, 3, 32'hFF, "R4");
    // R7 pending with an enable subset
    step(8'h22, 1, 0, 2, 32'h0F, "R7");
    step(8'h02, 0, 1, 1, 0, "R7");
    step(8'h02, 0, 1, 0, 0, "R7");
    step(8'h02, 0, 1, 6, 0, "R8");
    // R8 lowest pending wins
    step(8'h44, 1, 0, 2, 32'hFF, "R8");
    step(8'h44, 0, 1, 6, 0, "R8");
    step(8'h00, 1, 0, 3, 32'hFF, "R8");
    step(8'h00, 0, 1, 6, 0, "R8");
    step(8'h00, 0, 1, 1, 0, "R8");
    // R5 and R6 enable writes
    step(8'h08, 1, 0, 2, 32'h00, "R5");
    step(8'h00, 0, 1, 2, 0, "R5");
    step(8'h00, 1, 0, 4, 32'h09, "R6");
    step(8'h00, 0, 1, 2, 0, "R6");
    step(8'h00, 1, 0, 4, 32'h80, "R6");
    step(8'h00, 1, 0, 5, 32'h08, "R6");
    step(8'h00, 0, 1, 2, 0, "R6");
    // R9 master gate combinations with bit 0 pending
    step(8'h01, 1, 0, 7, 32'h1, "R9");
    step(8'h01, 0, 1, 7, 0, "R9");
    step(8'h01, 1, 0, 7, 32'h2, "R9");
    step(8'h01, 0, 1, 7, 0, "R9");
    step(8'h01, 1, 0, 7, 32'h3, "R9");
    step(8'h01, 0, 1, 7, 0, "R9");
    step(8'h01, 1, 0, 7, 32'h0, "R9");
    step(8'h00, 1, 0, 3, 32'hFF, "R9");
    // R10 write-only reads, idle read port, status write ignored
    step(8'h00, 0, 1, 3, 0, "R10");
    step(8'h00, 0, 1, 4, 0, "R10");
    step(8'h00, 0, 1, 5, 0, "R10");
    step(8'h00, 1, 0, 0, 32'hFFFF_FFFF, "R10");
    step(8'h00, 0, 1, 0, 0, "R10");
    step(8'h00, 0, 0, 2, 0, "R10");
    step(8'h00, 1, 0, 2, 32'hFFFF_FFFF, "R10");
    step(8'h00, 0, 1, 2, 0, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule